// File: doc/BRIEF.md
# Multi-Connection TCP Opener

This block sets up a batch of active TCP connections from one endpoint to a single remote host. On a start pulse it latches a destination IP address, a base port and a requested connection count. It then issues one open request per connection, where connection k goes to the base port plus k. The requests go out in increasing port order on a valid/ready request stream.

The block takes the open responses from a status stream in the order the requests were sent. Each response either carries a session ID or reports that the connection failed. Every session ID it receives is packed into the next free slot of an internal session table. A transmit engine can read that table through a plain index port. Failed opens only bump a failure counter and leave no table slot.

Once every request has been answered, the block raises a done flag and holds the sessions. A close command then sends each stored session ID, in table order, on a close stream. After that the table is emptied and the block returns to idle, ready for another batch.

Top module: `conn_fanout_opener`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `req_valid`, `close_valid` and `rsp_ready` are 0, and `ok_count` and `fail_count` are 0.
- R2: For a start with effective count N, exactly N open requests are issued. Request k carries `dst_ip` and port `base_port + k`, in increasing k. A request's fields hold steady while it waits for `req_ready`.
- R3: A requested count above MAX_CONN (default 16) is clamped to MAX_CONN.
- R4: Responses are matched to requests in issue order. A response with `rsp_ok=1` stores its session ID in the next consecutive table slot, starting at slot 0, and increments `ok_count`. Slot i is readable on `tbl_sid` when `tbl_idx=i`.
- R5: A response with `rsp_ok=0` increments `fail_count` and writes no table slot. A start clears both counters.
- R6: `done` rises only after one response per request has been accepted. With a count of 0, `done` is 1 in the cycle after the start pulse.
- R7: A start pulse is taken only when the block is idle. While opening, holding sessions or closing, a start changes no request, counter or table slot.
- R8: `close_cmd` is ignored unless `done` is 1. Once taken, every stored session ID is sent on `close_sid` in slot order. After that `ok_count` becomes 0 and the block returns to idle; with no stored sessions it returns to idle at once.
- R9: `rsp_ready` is 1 only while at least one issued request is still unanswered, so a response offered with nothing outstanding is never consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a batch of opens (taken only when idle) |
| conn_cnt | input | CW | Requested number of connections |
| dst_ip | input | IP_W | Destination IP address |
| base_port | input | PORT_W | First destination port |
| req_valid | output | 1 | Open request valid |
| req_ready | input | 1 | Open request accepted |
| req_ip | output | IP_W | Request destination IP |
| req_port | output | PORT_W | Request destination port |
| rsp_valid | input | 1 | Open response valid |
| rsp_ready | output | 1 | Open response accepted |
| rsp_ok | input | 1 | 1 = opened, 0 = failed |
| rsp_sid | input | SID_W | Session ID of an opened connection |
| close_cmd | input | 1 | Close all stored sessions (taken when done) |
| close_valid | output | 1 | Close request valid |
| close_ready | input | 1 | Close request accepted |
| close_sid | output | SID_W | Session ID to close |
| tbl_idx | input | IW | Session table read index |
| tbl_sid | output | SID_W | Session ID in slot `tbl_idx` |
| busy | output | 1 | Not idle |
| done | output | 1 | All responses received, sessions held |
| ok_count | output | CW | Number of stored sessions |
| fail_count | output | CW | Number of failed opens in this batch |

## Verification
The first batch has every open succeed and no back-pressure. It shows the plain port stepping and the direct fill of the table. The second batch mixes in failures and throttles the request and close streams. This tells whether the table stays compact across gaps, and whether requests and closes hold their fields while stalled. The same batch fires stray start and close pulses during opening, which separates accepted commands from ignored ones. An oversized count shows the clamp at MAX_CONN. A zero count shows the immediate done and the empty close. A response offered on every idle cycle shows that nothing is consumed without an outstanding request.

// File: rtl/conn_fanout_opener.sv
module conn_fanout_opener #(
  parameter int MAX_CONN = 16,
  parameter int SID_W    = 16,
  parameter int PORT_W   = 16,
  parameter int IP_W     = 32,
  localparam int CW = $clog2(MAX_CONN + 1),
  localparam int IW = (MAX_CONN > 1) ? $clog2(MAX_CONN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     conn_cnt,
  input  logic [IP_W-1:0]   dst_ip,
  input  logic [PORT_W-1:0] base_port,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IP_W-1:0]   req_ip,
  output logic [PORT_W-1:0] req_port,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_ok,
  input  logic [SID_W-1:0]  rsp_sid,
  input  logic              close_cmd,
  output logic              close_valid,
  input  logic              close_ready,
  output logic [SID_W-1:0]  close_sid,
  input  logic [IW-1:0]     tbl_idx,
  output logic [SID_W-1:0]  tbl_sid,
  output logic              busy,
  output logic              done,
  output logic [CW-1:0]     ok_count,
  output logic [CW-1:0]     fail_count
);

  typedef enum logic [1:0] {S_IDLE, S_OPEN, S_HOLD, S_CLOSE} st_t;

  st_t               st;
  logic [CW-1:0]     cnt_q, iss_n, rsp_n, ok_q, fail_q, cls_n;
  logic [IP_W-1:0]   ip_q;
  logic [PORT_W-1:0] base_q;
  logic [SID_W-1:0]  tab [MAX_CONN];
  logic [CW-1:0]     cnt_lim;

  assign cnt_lim     = (conn_cnt > CW'(MAX_CONN)) ? CW'(MAX_CONN) : conn_cnt;
  assign req_valid   = (st == S_OPEN) && (iss_n < cnt_q);
  assign req_ip      = ip_q;
  assign req_port    = base_q + PORT_W'(iss_n);
  assign rsp_ready   = (st == S_OPEN) && (rsp_n < iss_n);
  assign close_valid = (st == S_CLOSE);
  assign close_sid   = tab[cls_n[IW-1:0]];
  assign tbl_sid     = tab[tbl_idx];
  assign busy        = (st != S_IDLE);
  assign done        = (st == S_HOLD);
  assign ok_count    = ok_q;
  assign fail_count  = fail_q;

  wire req_fire = req_valid && req_ready;
  wire rsp_fire = rsp_valid && rsp_ready;
  wire cls_fire = close_valid && close_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt_q  <= '0;
      iss_n  <= '0;
      rsp_n  <= '0;
      ok_q   <= '0;
      fail_q <= '0;
      cls_n  <= '0;
      ip_q   <= '0;
      base_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cnt_q  <= cnt_lim;
          ip_q   <= dst_ip;
          base_q <= base_port;
          iss_n  <= '0;
          rsp_n  <= '0;
          ok_q   <= '0;
          fail_q <= '0;
          st     <= (cnt_lim == '0) ? S_HOLD : S_OPEN;
        end
        S_OPEN: begin
          if (req_fire) iss_n <= iss_n + 1'b1;
          if (rsp_fire) begin
            rsp_n <= rsp_n + 1'b1;
            if (rsp_ok) ok_q <= ok_q + 1'b1;
            else        fail_q <= fail_q + 1'b1;
            if (rsp_n + 1'b1 == cnt_q) st <= S_HOLD;
          end
        end
        S_HOLD: if (close_cmd) begin
          cls_n <= '0;
          st    <= (ok_q == '0) ? S_IDLE : S_CLOSE;
        end
        S_CLOSE: if (cls_fire) begin
          cls_n <= cls_n + 1'b1;
          if (cls_n + 1'b1 == ok_q) begin
            ok_q <= '0;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (st == S_OPEN && rsp_fire && rsp_ok) tab[ok_q[IW-1:0]] <= rsp_sid;

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_port) && $stable(req_ip)));

  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(MAX_CONN)) && (iss_n <= cnt_q));

  p_tally_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPEN) |-> (ok_q + fail_q == rsp_n));

  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (rsp_n == cnt_q));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cnt_q) && $stable(base_q));

  p_close_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (close_valid && !close_ready) |=> (close_valid && $stable(close_sid)));

  p_rsp_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (iss_n != rsp_n));

endmodule

// File: tb/conn_fanout_opener_test.sv
module conn_fanout_opener_test;
  localparam int MAXC = 16;
  localparam int CW = $clog2(MAXC + 1);
  localparam int IW = $clog2(MAXC);

  logic clk = 0, rst_n = 0;
  logic start = 0, close_cmd = 0;
  logic [CW-1:0] conn_cnt = '0;
  logic [31:0] dst_ip = '0;
  logic [15:0] base_port = '0;
  logic req_valid, req_ready = 0, rsp_ready, close_valid, close_ready = 0;
  logic [31:0] req_ip;
  logic [15:0] req_port, close_sid, tbl_sid;
  logic rsp_valid = 0, rsp_ok = 0;
  logic [15:0] rsp_sid = '0;
  logic [IW-1:0] tbl_idx = '0;
  logic busy, done;
  logic [CW-1:0] ok_count, fail_count;

  always #2.5 clk = ~clk;

  conn_fanout_opener #(.MAX_CONN(MAXC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .conn_cnt(conn_cnt), .dst_ip(dst_ip),
    .base_port(base_port), .req_valid(req_valid), .req_ready(req_ready), .req_ip(req_ip),
    .req_port(req_port), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
    .rsp_sid(rsp_sid), .close_cmd(close_cmd), .close_valid(close_valid),
    .close_ready(close_ready), .close_sid(close_sid), .tbl_idx(tbl_idx), .tbl_sid(tbl_sid),
    .busy(busy), .done(done), .ok_count(ok_count), .fail_count(fail_count));

  int vectors = 0, miscompares = 0, rsp_seen = 0, cyc = 0;
  bit stall = 0, finished = 0;
  int xp_port[$], xp_ip[$], plan_ok[$], plan_sid[$], pend_ok[$], pend_sid[$];
  int xp_tab[$], xp_close[$];

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc++;
    req_ready   = stall ? cyc[0] : 1'b1;
    close_ready = stall ? ~cyc[0] : 1'b1;
    if (req_valid && req_ready) begin
      if (xp_port.size() == 0) chk("R2 R7 unexpected request port", req_port, -1);
      else begin
        chk("R2 request port", req_port, xp_port.pop_front());
        chk("R2 request ip", req_ip, xp_ip.pop_front());
        pend_ok.push_back(plan_ok.pop_front());
        pend_sid.push_back(plan_sid.pop_front());
      end
    end
    rsp_valid = 1'b1;
    if (pend_ok.size() > 0) begin
      rsp_ok = pend_ok[0][0];
      rsp_sid = pend_sid[0][15:0];
    end else begin
      rsp_ok = 1'b1;
      rsp_sid = 16'hBAD0;
    end
    if (rsp_valid && rsp_ready) begin
      if (pend_ok.size() == 0) chk("R9 response taken with none outstanding", 1, 0);
      else begin
        void'(pend_ok.pop_front());
        void'(pend_sid.pop_front());
        rsp_seen++;
      end
    end
    if (close_valid && close_ready) begin
      if (xp_close.size() == 0) chk("R8 unexpected close", close_sid, -1);
      else chk("R8 close sid order", close_sid, xp_close.pop_front());
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 500 && !done; i++) @(negedge clk);
  endtask

  task automatic run_open(int n_in, int base, int ip, int fail_mask, int sid0, bit stray);
    int n = (n_in > MAXC) ? MAXC : n_in;
    xp_tab.delete();
    for (int k = 0; k < n; k++) begin
      xp_port.push_back(base + k);
      xp_ip.push_back(ip);
      plan_ok.push_back(!fail_mask[k]);
      plan_sid.push_back(sid0 + k);
      if (!fail_mask[k]) xp_tab.push_back(sid0 + k);
    end
    rsp_seen = 0;
    @(negedge clk);
    start = 1; conn_cnt = CW'(n_in); dst_ip = ip; base_port = base[15:0];
    @(negedge clk);
    start = 0;
    if (n > 0) chk("R6 done low while responses outstanding", done, 0);
    else chk("R6 zero count done next cycle", done, 1);
    if (stray) begin
      @(negedge clk);
      start = 1; conn_cnt = 3; base_port = 16'd9999; close_cmd = 1;
      @(negedge clk);
      start = 0; close_cmd = 0;
    end
    wait_done();
    chk("R6 done after all responses", rsp_seen, n);
    chk("R2 R3 requests issued", n - xp_port.size(), n);
    chk("R4 ok_count", ok_count, xp_tab.size());
    chk("R5 fail_count", fail_count, n - xp_tab.size());
    for (int i = 0; i < xp_tab.size(); i++) begin
      tbl_idx = IW'(i);
      #1 chk("R4 table slot", tbl_sid, xp_tab[i]);
    end
  endtask

  task automatic run_close();
    foreach (xp_tab[i]) xp_close.push_back(xp_tab[i]);
    @(negedge clk);
    close_cmd = 1;
    @(negedge clk);
    close_cmd = 0;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    chk("R8 all sessions closed", xp_close.size(), 0);
    chk("R8 ok_count cleared", ok_count, 0);
    chk("R8 back to idle", busy, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 close_valid", close_valid, 0);
    chk("R1 R9 rsp_ready", rsp_ready, 0);
    chk("R1 counts", ok_count + fail_count, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    run_open(5, 5000, 32'h0A01D479, 0, 16'h100, 0);
    run_close();

    stall = 1;
    run_open(6, 7000, 32'hC0A80002, 32'b010010, 16'h200, 1);
    chk("R7 R3 no stray requests", xp_port.size(), 0);
    run_close();
    stall = 0;

    run_open(20, 1200, 32'h0A000001, 32'h5A5A, 16'h300, 0);
    @(negedge clk);
    start = 1; conn_cnt = 2;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    chk("R7 start ignored while holding", ok_count, xp_tab.size());
    run_close();

    run_open(0, 40, 32'h01020304, 0, 0, 0);
    chk("R6 zero count no sessions", ok_count, 0);
    run_close();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    summary();
  end
endmodule